// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block drives the read side of a word-wide memory array during clocked burst reads. The host loads a 16-bit configuration word. It then asserts the select input and pulses the address-valid strobe with a start address. After a programmable initial latency the sequencer steps through the burst's word addresses, one per clock or one every two clocks. For each word it presents the array address, the data read from the array and a data-valid strobe. A WAIT output, with programmable polarity and timing, marks the cycles in which the data is not ready yet.

The address order is either wrapped inside an aligned window of 4, 8 or 16 words, or linear. A linear order runs across any bank boundary and rolls over from the top of the address space to zero. A continuous burst keeps stepping until select is removed. Removing select stops the burst at once. The outputs can be taken from the rising edge or delayed to the falling edge of the clock. The array is modelled as a registered lookup that returns a fixed function of the address.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, valid_o is 0, wait_o is 1, and arr_addr_o and data_o are 0. The reset configuration has bit 15 set and all other bits clear.
- R2: cfg_we_i loads cfg_wdata_i into the configuration on a rising edge. Bits [2:0] select the burst length: 1 gives 4 words, 2 gives 8 words, 3 gives 16 words and 7 gives a continuous burst. Any other code gives 4 words. A burst of finite length ends with valid_o low.
- R3: With bit 3 clear and a finite length N, word k of the burst is at address (start & ~(N-1)) | ((start+k) & (N-1)). With bit 3 set, word k is at start+k. A continuous burst always uses start+k.
- R4: Bits [13:11] give the latency L in clocks. Codes 0 and 1 act as 2. valid_o first rises L edges after the edge that samples adv_i.
- R5: Bit 10 sets the WAIT polarity: 1 makes wait_o active high and 0 makes it active low. wait_o sits at its inactive level whenever no latency period is running.
- R6: With bit 8 clear, WAIT is active in every latency cycle and inactive from the first valid word onward. With bit 8 set, WAIT goes inactive one cycle before the first valid word.
- R7: With bit 9 set, each word, with its address and data, is held for two clocks. With bit 9 clear, each word lasts one clock.
- R8: With bit 6 set, the outputs change on the rising edge. With bit 6 clear, the outputs change on the following falling edge and carry the same sequence.
- R9: With bit 15 set, the sequencer is in asynchronous mode: adv_i starts no burst and valid_o stays 0.
- R10: A linear burst crosses bank boundaries without a gap. Its address rolls over from 24'hFFFFFF to 0.
- R11: If sel_i is low at a rising edge, the sequencer goes idle at that edge, with valid_o low and wait_o inactive. While sel_i is low, adv_i is ignored.
- R12: While valid_o is high, data_o equals arr_addr_o[15:0] XOR 16'h5A3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration word |
| sel_i | input | 1 | Select (chip enable), active high |
| adv_i | input | 1 | Address-valid strobe, starts a burst |
| addr_i | input | 24 | Burst start address |
| arr_addr_o | output | 24 | Current array word address |
| data_o | output | 16 | Array read data |
| valid_o | output | 1 | Data-valid strobe |
| wait_o | output | 1 | WAIT, polarity set by configuration bit 10 |

## Verification
The assertions take for granted that the configuration is written only while no burst runs, and that the edge-select bit does not change in the middle of a burst. Under those conditions the wrap-window, hold and edge-path properties describe one fixed configuration. The bench drives all inputs a few nanoseconds after a rising edge. It writes each configuration with select low before raising adv_i. It drops select after every burst, so a new configuration never meets an active sequence.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;

  localparam int CFG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic       async_mode;
    logic [2:0] lat;
    logic       wait_hi;
    logic       hold2;
    logic       wait_early;
    logic       rise_edge;
    logic       no_wrap;
    logic [2:0] len_code;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.async_mode = w[15];
    c.lat        = w[13:11];
    c.wait_hi    = w[10];
    c.hold2      = w[9];
    c.wait_early = w[8];
    c.rise_edge  = w[6];
    c.no_wrap    = w[3];
    c.len_code   = w[2:0];
    return c;
  endfunction

  // 0 means continuous
  function automatic logic [4:0] len_words(input logic [2:0] code);
    case (code)
      3'd2:    return 5'd8;
      3'd3:    return 5'd16;
      3'd7:    return 5'd0;
      default: return 5'd4;
    endcase
  endfunction

endpackage

// File: rtl/bsr_cfg_reg.sv
`timescale 1ns/1ps
module bsr_cfg_reg
  import bsr_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RST = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_unused;

  always_comb begin
    cfg_d = we_i ? wdata_i : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (we_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o      = cfg_decode(cfg_q);
  assign cfg_unused = ^{cfg_q[14], cfg_q[7], cfg_q[5:4]};

endmodule

// File: rtl/bsr_ctrl.sv
`timescale 1ns/1ps
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          adv_i,
  input  logic [AW-1:0] start_addr_i,
  input  cfg_t          cfg_i,
  output logic          valid_o,
  output logic          wait_act_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] addr_nxt_o
);

  localparam int LW = 3;
  localparam int WW = 4;

  seq_state_e    st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          hold_q, hold_d;

  logic [4:0]    nwords;
  logic          finite;
  logic [AW-1:0] win_mask, addr_inc, addr_step;
  logic [LW-1:0] lat_eff;
  logic          upd_en;

  always_comb begin
    nwords   = len_words(cfg_i.len_code);
    finite   = (nwords != 5'd0);
    win_mask = AW'(nwords) - AW'(1);
    addr_inc = addr_q + AW'(1);
    if (finite && !cfg_i.no_wrap) begin
      addr_step = (addr_q & ~win_mask) | (addr_inc & win_mask);
    end else begin
      addr_step = addr_inc;
    end
    lat_eff = (cfg_i.lat < LW'(2)) ? LW'(2) : cfg_i.lat;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    wcnt_d = wcnt_q;
    hold_d = hold_q;
    if (!sel_i) begin
      st_d = ST_IDLE;
    end else if (adv_i && !cfg_i.async_mode) begin
      st_d   = ST_LAT;
      cnt_d  = lat_eff;
      addr_d = start_addr_i;
      wcnt_d = '0;
      hold_d = 1'b0;
    end else begin
      case (st_q)
        ST_LAT: begin
          if (cnt_q == LW'(1)) st_d = ST_DATA;
          else                 cnt_d = cnt_q - LW'(1);
        end
        ST_DATA: begin
          if (cfg_i.hold2 && !hold_q) begin
            hold_d = 1'b1;
          end else begin
            hold_d = 1'b0;
            if (finite && (5'(wcnt_q) == nwords - 5'd1)) begin
              st_d = ST_IDLE;
            end else begin
              wcnt_d = wcnt_q + WW'(1);
              addr_d = addr_step;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign upd_en = sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wcnt_q <= '0;
      hold_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (upd_en) begin
        cnt_q  <= cnt_d;
        addr_q <= addr_d;
        wcnt_q <= wcnt_d;
        hold_q <= hold_d;
      end
    end
  end

  assign valid_o    = (st_q == ST_DATA);
  assign wait_act_o = (st_q == ST_LAT) && (!cfg_i.wait_early || (cnt_q != LW'(1)));
  assign addr_o     = addr_q;
  assign addr_nxt_o = addr_d;

  assert_deselect_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (st_q == ST_IDLE));

  assert_async_no_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.async_mode && st_q == ST_IDLE) |=> (st_q == ST_IDLE));

  assert_latency_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_DATA) |-> ($past(st_q) == ST_LAT));

  assert_wrap_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && $past(st_q) == ST_DATA && finite && !cfg_i.no_wrap)
      |-> ((addr_q & ~win_mask) == ($past(addr_q) & ~win_mask)));

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && hold_q) |-> $stable(addr_q));

endmodule

// File: rtl/bsr_array.sv
`timescale 1ns/1ps
module bsr_array #(
  parameter int            AW       = 24,
  parameter int            DW       = 16,
  parameter logic [DW-1:0] DATA_KEY = 16'h5A3C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] data_q, data_d;

  always_comb begin
    data_d = DW'(rd_addr_i) ^ DATA_KEY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (rd_en_i) begin
      data_q <= data_d;
    end
  end

  assign rd_data_o = data_q;

endmodule

// File: rtl/bsr_edge_out.sv
`timescale 1ns/1ps
module bsr_edge_out #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rise_sel_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= RST_VAL;
    else         neg_q <= d_i;
  end

  assign q_o = rise_sel_i ? d_i : neg_q;

  assert_fall_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_sel_i && $stable(rise_sel_i)) |-> (q_o == d_i));

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq
  import bsr_pkg::*;
#(
  parameter int               AW       = 24,
  parameter int               DW       = 16,
  parameter logic [CFG_W-1:0] CFG_RST  = 16'h8000,
  parameter logic [DW-1:0]    DATA_KEY = 16'h5A3C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sel_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    addr_i,
  output logic [AW-1:0]    arr_addr_o,
  output logic [DW-1:0]    data_o,
  output logic             valid_o,
  output logic             wait_o
);

  localparam int            OW      = 2 + AW + DW;
  localparam logic [OW-1:0] OUT_RST = {1'b0, ~CFG_RST[10], {AW{1'b0}}, {DW{1'b0}}};

  logic [1:0]    rst_sync_q;
  logic          rst_n;
  cfg_t          cfg;
  logic          valid_c, wait_act;
  logic          wait_lvl;
  logic [AW-1:0] addr_c, addr_nxt;
  logic [DW-1:0] data_c;
  logic [OW-1:0] out_d, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bsr_cfg_reg #(.CFG_RST(CFG_RST)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  bsr_ctrl #(.AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .sel_i        (sel_i),
    .adv_i        (adv_i),
    .start_addr_i (addr_i),
    .cfg_i        (cfg),
    .valid_o      (valid_c),
    .wait_act_o   (wait_act),
    .addr_o       (addr_c),
    .addr_nxt_o   (addr_nxt)
  );

  bsr_array #(.AW(AW), .DW(DW), .DATA_KEY(DATA_KEY)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .rd_en_i   (sel_i),
    .rd_addr_i (addr_nxt),
    .rd_data_o (data_c)
  );

  assign wait_lvl = cfg.wait_hi ? wait_act : ~wait_act;
  assign out_d    = {valid_c, wait_lvl, addr_c, data_c};

  bsr_edge_out #(.W(OW), .RST_VAL(OUT_RST)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .rise_sel_i (cfg.rise_edge),
    .d_i        (out_d),
    .q_o        (out_q)
  );

  assign valid_o    = out_q[OW-1];
  assign wait_o     = out_q[OW-2];
  assign arr_addr_o = out_q[DW +: AW];
  assign data_o     = out_q[DW-1:0];

endmodule

// File: tb/burst_read_seq_tb.sv
`timescale 1ns/1ps
module burst_read_seq_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [15:0] cfg_wdata_i;
  logic        sel_i;
  logic        adv_i;
  logic [23:0] addr_i;
  logic [23:0] arr_addr_o;
  logic [15:0] data_o;
  logic        valid_o;
  logic        wait_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  burst_read_seq u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .sel_i       (sel_i),
    .adv_i       (adv_i),
    .addr_i      (addr_i),
    .arr_addr_o  (arr_addr_o),
    .data_o      (data_o),
    .valid_o     (valid_o),
    .wait_o      (wait_o)
  );

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step();
    @(posedge clk_i);
    #3;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit as, input int lat, input bit whi,
                                     input bit h2, input bit early, input bit rise,
                                     input bit nowrap, input int len);
    logic [2:0] l3 = lat[2:0];
    logic [2:0] n3 = len[2:0];
    return {as, 1'b0, l3, whi, h2, early, 1'b0, rise, 2'b00, nowrap, n3};
  endfunction

  task automatic write_cfg(input logic [15:0] w);
    cfg_we_i = 1'b1; cfg_wdata_i = w;
    step();
    cfg_we_i = 1'b0;
  endtask

  // Runs one burst and compares every cycle with the requirement model
  task automatic run_burst(input string req, input logic [15:0] cfg,
                           input logic [23:0] start, input int nobs);
    int n, l, h;
    bit whi, early, nowrap;
    write_cfg(cfg);
    case (cfg[2:0])
      3'd2: n = 8;
      3'd3: n = 16;
      3'd7: n = 0;
      default: n = 4;
    endcase
    l = (cfg[13:11] < 2) ? 2 : int'(cfg[13:11]);
    h = cfg[9] ? 2 : 1;
    whi = cfg[10]; early = cfg[8]; nowrap = cfg[3];
    sel_i = 1'b1; adv_i = 1'b1; addr_i = start;
    step();
    adv_i = 1'b0;
    for (int j = 0; j < nobs; j++) begin
      bit ve, wl;
      logic [23:0] ae;
      int k;
      ve = 1'b0; wl = 1'b0; ae = '0;
      if (j < l) begin
        wl = early ? (j < l - 1) : 1'b1;
      end else begin
        k = (j - l) / h;
        if (n == 0 || k < n) begin
          ve = 1'b1;
          if (n != 0 && !nowrap)
            ae = (start & ~24'(n - 1)) | ((start + 24'(k)) & 24'(n - 1));
          else
            ae = start + 24'(k);
        end
      end
      check(req, "valid", 32'(valid_o), 32'(ve));
      check(req, "wait", 32'(wait_o), 32'(whi ? wl : !wl));
      if (ve) begin
        check(req, "addr", 32'(arr_addr_o), 32'(ae));
        check("R12", "data", 32'(data_o), 32'(ae[15:0] ^ 16'h5A3C));
      end
      step();
    end
    sel_i = 1'b0;
    step();
    step();
  endtask

  task automatic t_reset();
    check("R1", "valid", 32'(valid_o), 32'd0);
    check("R1", "wait", 32'(wait_o), 32'd1);
    check("R1", "addr", 32'(arr_addr_o), 32'd0);
    check("R1", "data", 32'(data_o), 32'd0);
  endtask

  task automatic t_wraps();
    run_burst("R3", mk(0, 3, 0, 0, 0, 1, 0, 1), 24'h000001, 10);
    run_burst("R3", mk(0, 4, 0, 0, 0, 1, 0, 2), 24'h000207, 14);
    run_burst("R3", mk(0, 2, 0, 0, 0, 1, 0, 1), 24'h00010D, 9);
    run_burst("R2", mk(0, 2, 0, 0, 0, 1, 0, 3), 24'h00031B, 20);
    run_burst("R2", mk(0, 2, 0, 0, 0, 1, 0, 5), 24'h000042, 9);
  endtask

  task automatic t_linear();
    run_burst("R10", mk(0, 3, 0, 0, 0, 1, 1, 2), 24'h00FFFE, 13);
    run_burst("R10", mk(0, 5, 0, 0, 0, 1, 0, 7), 24'hFFFFFD, 14);
  endtask

  task automatic t_latency();
    run_burst("R4", mk(0, 0, 0, 0, 0, 1, 0, 1), 24'h000020, 8);
    run_burst("R4", mk(0, 1, 1, 0, 0, 1, 0, 1), 24'h000024, 8);
    run_burst("R4", mk(0, 7, 0, 0, 0, 1, 0, 1), 24'h000028, 13);
  endtask

  task automatic t_wait();
    run_burst("R5", mk(0, 4, 1, 0, 0, 1, 0, 1), 24'h000050, 10);
    run_burst("R6", mk(0, 4, 1, 0, 1, 1, 0, 1), 24'h000054, 10);
    run_burst("R6", mk(0, 5, 0, 0, 1, 1, 0, 2), 24'h000063, 15);
  endtask

  task automatic t_hold();
    run_burst("R7", mk(0, 3, 0, 1, 0, 1, 0, 1), 24'h000072, 13);
    run_burst("R7", mk(0, 2, 1, 1, 1, 1, 1, 2), 24'h0000FC, 20);
  endtask

  // Samples one nanosecond after the edge of the first valid word
  task automatic t_edge(input bit rise);
    write_cfg(mk(0, 3, 0, 0, 0, rise, 0, 1));
    sel_i = 1'b1; adv_i = 1'b1; addr_i = 24'h000090;
    step();
    adv_i = 1'b0;
    step();
    step();
    @(posedge clk_i);
    #1;
    check("R8", "valid_early_sample", 32'(valid_o), 32'(rise));
    #2;
    check("R8", "valid_late_sample", 32'(valid_o), 32'd1);
    check("R8", "addr", 32'(arr_addr_o), 32'h90);
    sel_i = 1'b0;
    step();
    step();
  endtask

  task automatic t_falling();
    run_burst("R8", mk(0, 3, 0, 0, 0, 0, 0, 2), 24'h0000A5, 13);
    t_edge(1'b0);
    t_edge(1'b1);
  endtask

  task automatic t_async();
    write_cfg(mk(1, 2, 0, 0, 0, 1, 0, 1));
    sel_i = 1'b1; adv_i = 1'b1; addr_i = 24'h000030;
    step();
    adv_i = 1'b0;
    for (int j = 0; j < 8; j++) begin
      check("R9", "valid", 32'(valid_o), 32'd0);
      step();
    end
    sel_i = 1'b0;
    step();
  endtask

  task automatic t_deselect();
    write_cfg(mk(0, 2, 1, 0, 0, 1, 0, 7));
    sel_i = 1'b1; adv_i = 1'b1; addr_i = 24'h000400;
    step();
    adv_i = 1'b0;
    for (int j = 0; j < 5; j++) step();
    check("R11", "valid_before", 32'(valid_o), 32'd1);
    sel_i = 1'b0;
    step();
    check("R11", "valid_after", 32'(valid_o), 32'd0);
    check("R11", "wait_after", 32'(wait_o), 32'd0);
    adv_i = 1'b1; addr_i = 24'h000500;
    step();
    adv_i = 1'b0;
    for (int j = 0; j < 6; j++) begin
      check("R11", "valid_sel_low", 32'(valid_o), 32'd0);
      check("R11", "wait_sel_low", 32'(wait_o), 32'd0);
      step();
    end
  endtask

  initial begin
    rst_ni = 1'b0; cfg_we_i = 1'b0; cfg_wdata_i = '0;
    sel_i = 1'b0; adv_i = 1'b0; addr_i = '0;
    repeat (4) step();
    rst_ni = 1'b1;
    repeat (4) step();
    t_reset();
    t_wraps();
    t_linear();
    t_latency();
    t_wait();
    t_hold();
    t_falling();
    t_async();
    t_deselect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule